// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block collects fifteen external interrupt lines, numbered 1 to 15, and routes them to a configurable number of processors, from one to sixteen. A rising edge on a line either marks the line in a shared pending vector or, if the line is chosen for broadcast, marks it in every processor's private force vector. Each processor sees the union of the shared pending vector and its own force vector, filtered by its own mask. It receives the number of the winning request on a registered 4-bit request output.

Sources are split into two priority groups by a level register. A request in the high group always beats one in the low group, and within a group the highest number wins. A processor retires an interrupt by pulsing its acknowledge input with the interrupt number. Software reaches all state through a simple 32-bit word register port with an 8-bit byte address and combinational read data.

Top module: `mpirq_ctrl`

## Requirements
- R1: Register byte offsets: 0x00 level, 0x04 pending, 0x08 processor-0 force alias, 0x0C clear, 0x14 broadcast, 0x40+4*i mask of processor i, 0x80+4*i force of processor i (i below NCPU). Each register appears in read data bits 15:0, and bits 31:16 read as zero.
- R2: Bit 0 (interrupt 0 does not exist) and bits 31:16 are dropped on writes to level, mask, alias and broadcast. For example, writing 0xFFFFFFFF to level reads back 0x0000FFFE.
- R3: On a rising edge of input line n (n in 1..15): if broadcast bit n is 1, bit n is set in every processor's force register and pending is left unchanged. Otherwise bit n is set in pending.
- R4: For processor i the effective request is (pending OR force_i) AND mask_i. If any effective request has its level bit at 1, only those requests compete; otherwise all the effective requests compete.
- R5: A write to the force register of processor i takes wdata bits 15:1 as bits to set and bits 31:17 as bits to clear. The new value is (old OR set) AND NOT clear.
- R6: Pending is read-only. Offset 0x0C always reads zero, and a write to it removes the written bits 15:1 from pending and from every force register.
- R7: An acknowledge from processor i with 4-bit number n clears bit n in pending and in force_i only.
- R8: A write to 0x08 replaces processor 0's force register with wdata bits 15:1. A read at 0x08 returns that register.
- R9: All registers and outputs reset to zero. Reads of other offsets (including 0x10, misaligned offsets and processor slots at or above NCPU) return zero, and writes to them change nothing.
- R10: Each 4-bit request output carries the highest-numbered request of the winning group, or zero when none is active. It is registered and reflects the state one clock after that state changes.
- R11: If a source edge and an acknowledge or clear for the same bit fall in the same cycle, the new edge wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 16 | Interrupt lines; bit n is line n, bit 0 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| ack_valid_i | input | NCPU | Acknowledge strobe per processor |
| ack_num_i | input | 4*NCPU | Acknowledged number, processor i in bits 4i+3:4i |
| req_level_o | output | 4*NCPU | Request number per processor, processor i in bits 4i+3:4i |

## Verification
A new rising edge on a line can land in the same cycle as an acknowledge of that same number. This is the collision where an event can be lost. The bench first sets the pending bit for line 7, then raises line 7 again on the same clock edge where processor 0 acknowledges 7. It expects pending to still show bit 7 afterwards, and then confirms that a lone acknowledge does clear it.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
   localparam int unsigned SRC_W  = 16;
   localparam int unsigned NUM_W  = 4;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned ADDR_W = 8;

   typedef logic [SRC_W-1:0] src_vec_t;

   localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_ALIAS = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_BCAST = 8'h14;
   localparam logic [1:0]        BANK_MASK = 2'b01;
   localparam logic [1:0]        BANK_FRC  = 2'b10;

   localparam src_vec_t VALID_BITS = 16'hFFFE;

   function automatic logic [NUM_W-1:0] top_index(input src_vec_t v);
      logic [NUM_W-1:0] r;
      r = '0;
      for (int k = 1; k < int'(SRC_W); k++)
         if (v[k]) r = NUM_W'(k);
      return r;
   endfunction
endpackage

// File: rtl/mpirq_edge.sv
module mpirq_edge
   import mpirq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t lines_i,
   output src_vec_t rise_o
);
   src_vec_t prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines_i;
   end

   assign rise_o = lines_i & ~prev_q & VALID_BITS;
endmodule

// File: rtl/mpirq_slice.sv
module mpirq_slice
   import mpirq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we_i,
   input  logic              frc_we_i,
   input  logic              alias_we_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  src_vec_t          clr_i,
   input  src_vec_t          bc_rise_i,
   input  src_vec_t          pend_i,
   input  src_vec_t          level_i,
   input  logic              ack_i,
   input  logic [NUM_W-1:0]  ack_num_i,
   output src_vec_t          ack_bits_o,
   output src_vec_t          mask_o,
   output src_vec_t          frc_o,
   output logic [NUM_W-1:0]  irl_o
);
   src_vec_t mask_q, frc_q, frc_base, eff, hi, pick;

   always_comb begin
      ack_bits_o = '0;
      if (ack_i) ack_bits_o[ack_num_i] = 1'b1;
   end

   always_comb begin
      frc_base = frc_q;
      if (alias_we_i)
         frc_base = wdata_i[SRC_W-1:0] & VALID_BITS;
      else if (frc_we_i)
         frc_base = (frc_q | (wdata_i[SRC_W-1:0] & VALID_BITS))
                    & ~(wdata_i[WORD_W-1:SRC_W] & VALID_BITS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         frc_q  <= '0;
      end else begin
         if (mask_we_i) mask_q <= wdata_i[SRC_W-1:0] & VALID_BITS;
         frc_q <= (frc_base & ~clr_i & ~ack_bits_o) | bc_rise_i;
      end
   end

   assign eff  = (pend_i | frc_q) & mask_q;
   assign hi   = eff & level_i;
   assign pick = (hi != '0) ? hi : eff;

   always_ff @(posedge clk) begin
      if (!rst_n) irl_o <= '0;
      else        irl_o <= top_index(pick);
   end

   assign mask_o = mask_q;
   assign frc_o  = frc_q;
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
   import mpirq_pkg::*;
#(
   parameter int unsigned NCPU = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [15:0]             irq_lines_i,
   input  logic                    reg_we_i,
   input  logic [7:0]              reg_addr_i,
   input  logic [31:0]             reg_wdata_i,
   output logic [31:0]             reg_rdata_o,
   input  logic [NCPU-1:0]         ack_valid_i,
   input  logic [4*NCPU-1:0]       ack_num_i,
   output logic [4*NCPU-1:0]       req_level_o
);
   localparam int unsigned IDX_W = 4;

   if (NCPU < 1 || NCPU > 16) begin : g_bad_ncpu
      $error("mpirq_ctrl: NCPU must lie in 1..16");
   end

   src_vec_t rise, rise_nb, rise_bc, clr_bits, ack_all;
   src_vec_t lvl_q, pend_q, bcast_q;
   src_vec_t mask_a [NCPU];
   src_vec_t frc_a  [NCPU];
   src_vec_t ackb_a [NCPU];

   logic             aligned, wr_level, wr_alias, wr_clear, wr_bcast;
   logic [1:0]       bank;
   logic [IDX_W-1:0] slot;
   logic             slot_ok;

   assign aligned  = reg_addr_i[1:0] == 2'b00;
   assign bank     = reg_addr_i[7:6];
   assign slot     = reg_addr_i[5:2];
   assign slot_ok  = aligned && (int'(slot) < int'(NCPU));
   assign wr_level = reg_we_i && reg_addr_i == OFS_LEVEL;
   assign wr_alias = reg_we_i && reg_addr_i == OFS_ALIAS;
   assign wr_clear = reg_we_i && reg_addr_i == OFS_CLEAR;
   assign wr_bcast = reg_we_i && reg_addr_i == OFS_BCAST;
   assign clr_bits = wr_clear ? (reg_wdata_i[SRC_W-1:0] & VALID_BITS) : '0;

   mpirq_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (irq_lines_i),
      .rise_o  (rise)
   );

   assign rise_bc = rise & bcast_q;
   assign rise_nb = rise & ~bcast_q;

   always_comb begin
      ack_all = '0;
      for (int c = 0; c < int'(NCPU); c++) ack_all |= ackb_a[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         pend_q  <= '0;
         bcast_q <= '0;
      end else begin
         if (wr_level) lvl_q   <= reg_wdata_i[SRC_W-1:0] & VALID_BITS;
         if (wr_bcast) bcast_q <= reg_wdata_i[SRC_W-1:0] & VALID_BITS;
         pend_q <= (pend_q & ~clr_bits & ~ack_all) | rise_nb;
      end
   end

   for (genvar g = 0; g < int'(NCPU); g++) begin : g_cpu
      logic sel_mask, sel_frc;
      assign sel_mask = reg_we_i && slot_ok && bank == BANK_MASK && slot == IDX_W'(g);
      assign sel_frc  = reg_we_i && slot_ok && bank == BANK_FRC  && slot == IDX_W'(g);

      mpirq_slice u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .mask_we_i  (sel_mask),
         .frc_we_i   (sel_frc),
         .alias_we_i ((g == 0) && wr_alias),
         .wdata_i    (reg_wdata_i),
         .clr_i      (clr_bits),
         .bc_rise_i  (rise_bc),
         .pend_i     (pend_q),
         .level_i    (lvl_q),
         .ack_i      (ack_valid_i[g]),
         .ack_num_i  (ack_num_i[g*NUM_W +: NUM_W]),
         .ack_bits_o (ackb_a[g]),
         .mask_o     (mask_a[g]),
         .frc_o      (frc_a[g]),
         .irl_o      (req_level_o[g*NUM_W +: NUM_W])
      );
   end

   always_comb begin
      src_vec_t v;
      v = '0;
      case (reg_addr_i)
         OFS_LEVEL: v = lvl_q;
         OFS_PEND:  v = pend_q;
         OFS_ALIAS: v = frc_a[0];
         OFS_BCAST: v = bcast_q;
         default: begin
            for (int c = 0; c < int'(NCPU); c++) begin
               if (slot_ok && int'(slot) == c && bank == BANK_MASK) v = mask_a[c];
               if (slot_ok && int'(slot) == c && bank == BANK_FRC)  v = frc_a[c];
            end
         end
      endcase
      reg_rdata_o = {{(WORD_W-SRC_W){1'b0}}, v};
   end
endmodule

// File: rtl/mpirq_chk.sv
module mpirq_chk
   import mpirq_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input src_vec_t    rise_nb,
   input src_vec_t    pend_q,
   input src_vec_t    lvl_q,
   input src_vec_t    bcast_q,
   input src_vec_t    mask0,
   input logic [7:0]  reg_addr_i,
   input logic [31:0] reg_rdata_o,
   input logic [3:0]  irl0
);
   // R3: a pending bit appears only after a non-broadcast edge of that line
   p_pend_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_nb)) == '0));

   // R2: bit 0 never held
   p_bit0_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[0] == 1'b0) && (bcast_q[0] == 1'b0) && (pend_q[0] == 1'b0));

   // R4: a fully masked processor gets no request next cycle
   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask0 == '0) |=> (irl0 == 4'd0));

   // R6: clear offset reads zero
   p_clear_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == 8'h0C) |-> (reg_rdata_o == 32'd0));

   // R9: high half of read data is zero
   p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[31:16] == 16'd0);
endmodule

bind mpirq_ctrl mpirq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rise_nb     (rise_nb),
   .pend_q      (pend_q),
   .lvl_q       (lvl_q),
   .bcast_q     (bcast_q),
   .mask0       (mask_a[0]),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .irl0        (req_level_o[3:0])
);

// File: tb/sim_mpirq_ctrl.sv
module sim_mpirq_ctrl;
   localparam int NCPU = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       lines = '0;
   logic              we = 1'b0;
   logic [7:0]        addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [NCPU-1:0]   ackv = '0;
   logic [4*NCPU-1:0] ackn = '0;
   logic [4*NCPU-1:0] irl;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mpirq_ctrl #(.NCPU(NCPU)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .ack_valid_i(ackv), .ack_num_i(ackn), .req_level_o(irl)
   );

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      tick();
      we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      addr = a; #1;
      chk(req, rdata, exp);
   endtask

   task automatic pulse(input int n);
      lines[n] = 1'b1; tick();
      lines[n] = 1'b0; tick();
   endtask

   task automatic ack(input int cpu, input int n);
      ackv[cpu] = 1'b1; ackn[cpu*4 +: 4] = 4'(n);
      tick();
      ackv[cpu] = 1'b0;
   endtask

   function automatic logic [31:0] lvl(input int cpu);
      return {28'd0, irl[cpu*4 +: 4]};
   endfunction

   task automatic t_reset();
      chk("R9 reset outputs", {16'd0, irl}, 32'd0);
      rd("R9 reset level", 8'h00, 32'd0);
      rd("R9 reset pending", 8'h04, 32'd0);
   endtask

   task automatic t_basic();
      wr(8'h40, 32'hFFFF_FFFF);
      rd("R2 mask bit0 and upper dropped", 8'h40, 32'h0000_FFFE);
      pulse(5);
      rd("R3 edge sets pending", 8'h04, 32'h0000_0020);
      chk("R10 single request cpu0", lvl(0), 32'd5);
      chk("R4 masked cpu1 quiet", lvl(1), 32'd0);
   endtask

   task automatic t_prio();
      pulse(9);
      chk("R10 highest number wins", lvl(0), 32'd9);
      wr(8'h00, 32'h0000_0020); tick();
      chk("R4 high group beats higher number", lvl(0), 32'd5);
      wr(8'h00, 32'h0000_0000); tick();
      chk("R4 groups merged again", lvl(0), 32'd9);
   endtask

   task automatic t_ack();
      ack(0, 9);
      rd("R7 ack clears pending bit", 8'h04, 32'h0000_0020);
      tick();
      chk("R7 next request shown", lvl(0), 32'd5);
   endtask

   task automatic t_clear();
      wr(8'h0C, 32'h0000_0021);
      rd("R6 clear empties pending", 8'h04, 32'd0);
      rd("R6 clear reads zero", 8'h0C, 32'd0);
      tick();
      chk("R10 no request gives zero", lvl(0), 32'd0);
      wr(8'h04, 32'h0000_FFFF);
      rd("R6 pending write ignored", 8'h04, 32'd0);
   endtask

   task automatic t_bcast();
      wr(8'h14, 32'h0000_0009);
      rd("R2 broadcast bit0 dropped", 8'h14, 32'h0000_0008);
      pulse(3);
      rd("R3 broadcast skips pending", 8'h04, 32'd0);
      rd("R3 broadcast into force1", 8'h84, 32'h0000_0008);
      rd("R1 alias shows force0", 8'h08, 32'h0000_0008);
      wr(8'h44, 32'h0000_0008); tick();
      chk("R3 cpu1 sees broadcast", lvl(1), 32'd3);
   endtask

   task automatic t_force();
      wr(8'h88, 32'h0008_0006);
      rd("R5 force set and clear", 8'h88, 32'h0000_0006);
      wr(8'h0C, 32'h0000_0008);
      rd("R6 clear removes force0", 8'h80, 32'd0);
      rd("R6 clear removes force3", 8'h8C, 32'd0);
      rd("R6 unrelated force bits kept", 8'h88, 32'h0000_0006);
   endtask

   task automatic t_alias();
      wr(8'h80, 32'h0000_0010);
      wr(8'h08, 32'h0000_F001);
      rd("R8 alias replaces force0", 8'h80, 32'h0000_F000);
      wr(8'h08, 32'd0);
   endtask

   task automatic t_undef();
      wr(8'h20, 32'hFFFF_FFFF);
      rd("R9 undefined reads zero", 8'h20, 32'd0);
      rd("R9 offset 0x10 reads zero", 8'h10, 32'd0);
      wr(8'h50, 32'hFFFF_FFFF);
      rd("R9 slot beyond NCPU zero", 8'h50, 32'd0);
      rd("R9 other masks untouched", 8'h48, 32'd0);
      wr(8'h00, 32'hFFFF_FFFF);
      rd("R2 level keeps 15:1", 8'h00, 32'h0000_FFFE);
      wr(8'h00, 32'd0);
   endtask

   task automatic t_collide();
      wr(8'h14, 32'd0);
      pulse(7);
      rd("R3 line 7 pending", 8'h04, 32'h0000_0080);
      lines[7] = 1'b1; ackv[0] = 1'b1; ackn[3:0] = 4'd7;
      tick();
      lines[7] = 1'b0; ackv[0] = 1'b0;
      rd("R11 edge beats same-cycle ack", 8'h04, 32'h0000_0080);
      ack(0, 7);
      rd("R7 lone ack clears", 8'h04, 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_basic();
      t_prio();
      t_ack();
      t_clear();
      t_bcast();
      t_force();
      t_alias();
      t_undef();
      t_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule